// File: doc/BRIEF.md
# Single-Level Fast Context Shadow

This block keeps one saved copy of three core registers: the status flags, the working register and the bank-select register. It supports a fast return from an interrupt or a subroutine. The core raises a vector strobe whenever it enters an interrupt, from any source, and a fast-call strobe when it executes a call flagged for fast context. On either strobe the block copies the current values of the three live registers into the shadow. When the core executes a return flagged as fast, the block presents the saved values on its restore outputs and raises a load enable, so the core writes them back into the live registers.

Software cannot reach the shadow. There is only one level, so each capture replaces the previous one. If a high-priority interrupt arrives while a low-priority handler is running, the second capture overwrites the values the low-priority handler saved, and that handler must save its context in software instead. A return without the fast flag does not touch the shadow. The parameter `RESTORE_LAT` sets when the restore appears. With 0 it appears in the same cycle as the return strobe, for a core that loads on that edge. With 1 it appears registered, one cycle later.

Top module: `fast_ctx_shadow`

## Requirements
- R1: Reset clears all three shadow fields to zero. A fast return as the first operation after reset delivers zero for status, working and bank-select values, and `rest_load` is low while reset is asserted.
- R2: In a cycle with `vec_irq` high, the shadow takes the live status, working and bank-select values at that clock edge.
- R3: In a cycle with `call_fast` high, the shadow takes the live values in the same way. When `call_fast` and `vec_irq` are high together, a single capture occurs.
- R4: A cycle with `ret_exec` and `ret_is_fast` both high and no capture strobe is a fast return. It raises `rest_load` for one cycle with the shadow contents on `rest_status`, `rest_wreg` and `rest_bsr`. This happens in the same cycle when `RESTORE_LAT`=0 and in the next cycle when `RESTORE_LAT`=1.
- R5: A return with `ret_is_fast` low leaves `rest_load` low and does not change the shadow. Changes on the live inputs without a capture strobe also leave the shadow unchanged.
- R6: A capture overwrites any earlier capture, whether or not that earlier capture has been restored. A later fast return delivers only the newest values.
- R7: When a capture strobe and a fast return occur in the same cycle, the capture wins. No load is issued and the shadow takes the new live values.
- R8: A fast return does not consume the shadow. Repeated fast returns with no capture in between deliver the same values.
- R9: Whenever `rest_load` is low, `rest_status`, `rest_wreg` and `rest_bsr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| live_status | input | STATUS_W | Current status register value |
| live_wreg | input | WREG_W | Current working register value |
| live_bsr | input | BSR_W | Current bank-select register value |
| vec_irq | input | 1 | Core is vectoring to an interrupt this cycle |
| call_fast | input | 1 | Core executes a call flagged fast this cycle |
| ret_exec | input | 1 | Core executes a return of any kind this cycle |
| ret_is_fast | input | 1 | The return in this cycle is flagged fast |
| rest_load | output | 1 | Load enable for the three live registers |
| rest_status | output | STATUS_W | Status value to restore |
| rest_wreg | output | WREG_W | Working register value to restore |
| rest_bsr | output | BSR_W | Bank-select value to restore |

## Verification
The bench builds two instances side by side with the default widths of 5, 8 and 8 bits. One uses `RESTORE_LAT`=0 and the other `RESTORE_LAT`=1. A single stimulus stream therefore checks both the same-cycle restore path and the registered restore path against one behavioural model. The registered instance shows whether the one-cycle delay preserves the capture-wins rule and the all-zero idle output.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

   // Action the shadow performs in the current cycle.
   typedef enum logic [1:0] {
      FCS_IDLE    = 2'd0,
      FCS_CAPTURE = 2'd1,
      FCS_RESTORE = 2'd2
   } fcs_op_e;

   // Number of saved fields: status, working, bank select.
   localparam int FCS_NUM_FIELDS = 3;

endpackage

// File: rtl/fcs_arbiter.sv
module fcs_arbiter
   import fcs_pkg::*;
(
   input  logic    vec_irq,
   input  logic    call_fast,
   input  logic    ret_exec,
   input  logic    ret_is_fast,
   output fcs_op_e op
);

   logic capture_req;
   logic restore_req;

   assign capture_req = vec_irq | call_fast;
   assign restore_req = ret_exec & ret_is_fast;

   // A capture outranks a restore in the same cycle.
   always_comb begin
      if (capture_req)      op = FCS_CAPTURE;
      else if (restore_req) op = FCS_RESTORE;
      else                  op = FCS_IDLE;
   end

endmodule

// File: rtl/fcs_shadow_field.sv
module fcs_shadow_field #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap_en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("fcs_shadow_field: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (cap_en) q <= d;
   end

endmodule

// File: rtl/fcs_restore_stage.sv
module fcs_restore_stage #(
   parameter int TOTAL_W     = 21,
   parameter int RESTORE_LAT = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire,
   input  logic [TOTAL_W-1:0] shadow,
   output logic               load,
   output logic [TOTAL_W-1:0] data
);

   logic [TOTAL_W-1:0] gated;

   // Outputs stay zero unless a load is issued.
   assign gated = fire ? shadow : '0;

   if (RESTORE_LAT == 0) begin : g_comb
      assign load = fire;
      assign data = gated;
   end else begin : g_reg
      logic               load_q;
      logic [TOTAL_W-1:0] data_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            load_q <= 1'b0;
            data_q <= '0;
         end else begin
            load_q <= fire;
            data_q <= gated;
         end
      end
      assign load = load_q;
      assign data = data_q;
   end

endmodule

// File: rtl/fast_ctx_shadow.sv
module fast_ctx_shadow
   import fcs_pkg::*;
#(
   parameter int STATUS_W    = 5,
   parameter int WREG_W      = 8,
   parameter int BSR_W       = 8,
   parameter int RESTORE_LAT = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [STATUS_W-1:0] live_status,
   input  logic [WREG_W-1:0]   live_wreg,
   input  logic [BSR_W-1:0]    live_bsr,
   input  logic                vec_irq,
   input  logic                call_fast,
   input  logic                ret_exec,
   input  logic                ret_is_fast,
   output logic                rest_load,
   output logic [STATUS_W-1:0] rest_status,
   output logic [WREG_W-1:0]   rest_wreg,
   output logic [BSR_W-1:0]    rest_bsr
);

   localparam int TOTAL_W = STATUS_W + WREG_W + BSR_W;
   localparam int OFS_ST  = 0;
   localparam int OFS_WR  = STATUS_W;
   localparam int OFS_BS  = STATUS_W + WREG_W;

   if (STATUS_W < 1 || WREG_W < 1 || BSR_W < 1) begin : g_bad_width
      $error("fast_ctx_shadow: every field width must be at least 1");
   end
   if (RESTORE_LAT < 0 || RESTORE_LAT > 1) begin : g_bad_lat
      $error("fast_ctx_shadow: RESTORE_LAT must be 0 or 1");
   end

   function automatic int fld_w(int idx);
      case (idx)
         0:       return STATUS_W;
         1:       return WREG_W;
         default: return BSR_W;
      endcase
   endfunction

   function automatic int fld_o(int idx);
      case (idx)
         0:       return OFS_ST;
         1:       return OFS_WR;
         default: return OFS_BS;
      endcase
   endfunction

   fcs_op_e            op;
   logic               cap_en;
   logic               fire;
   logic [TOTAL_W-1:0] live_bus;
   logic [TOTAL_W-1:0] shadow_bus;
   logic [TOTAL_W-1:0] rest_bus;

   assign live_bus = {live_bsr, live_wreg, live_status};

   fcs_arbiter u_arb (
      .vec_irq     (vec_irq),
      .call_fast   (call_fast),
      .ret_exec    (ret_exec),
      .ret_is_fast (ret_is_fast),
      .op          (op)
   );

   assign cap_en = (op == FCS_CAPTURE);
   assign fire   = (op == FCS_RESTORE);

   for (genvar g = 0; g < FCS_NUM_FIELDS; g++) begin : g_fld
      localparam int W = fld_w(g);
      localparam int O = fld_o(g);
      fcs_shadow_field #(.W(W)) u_field (
         .clk    (clk),
         .rst_n  (rst_n),
         .cap_en (cap_en),
         .d      (live_bus[O +: W]),
         .q      (shadow_bus[O +: W])
      );
   end

   fcs_restore_stage #(
      .TOTAL_W     (TOTAL_W),
      .RESTORE_LAT (RESTORE_LAT)
   ) u_rest (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (fire),
      .shadow (shadow_bus),
      .load   (rest_load),
      .data   (rest_bus)
   );

   assign rest_status = rest_bus[OFS_ST +: STATUS_W];
   assign rest_wreg   = rest_bus[OFS_WR +: WREG_W];
   assign rest_bsr    = rest_bus[OFS_BS +: BSR_W];

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
   parameter int STATUS_W    = 5,
   parameter int WREG_W      = 8,
   parameter int BSR_W       = 8,
   parameter int RESTORE_LAT = 0
) (
   input logic                clk,
   input logic                rst_n,
   input logic [STATUS_W-1:0] live_status,
   input logic [WREG_W-1:0]   live_wreg,
   input logic [BSR_W-1:0]    live_bsr,
   input logic                vec_irq,
   input logic                call_fast,
   input logic                ret_exec,
   input logic                ret_is_fast,
   input logic                rest_load,
   input logic [STATUS_W-1:0] rest_status,
   input logic [WREG_W-1:0]   rest_wreg,
   input logic [BSR_W-1:0]    rest_bsr
);

   AST_IDLE_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rest_load |-> (rest_status == '0 && rest_wreg == '0 && rest_bsr == '0)); // R9

   if (RESTORE_LAT == 0) begin : g_lat0
      AST_PLAIN_RET_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         (ret_exec && !ret_is_fast) |-> !rest_load); // R5
      AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         (vec_irq || call_fast) |-> !rest_load); // R7
      AST_LOAD_ONLY_ON_FAST_RET: assert property (@(posedge clk) disable iff (!rst_n)
         rest_load |-> (ret_exec && ret_is_fast)); // R4
      AST_IRQ_SAVED_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(vec_irq) && ret_exec && ret_is_fast && !vec_irq && !call_fast) |->
         (rest_status == $past(live_status) && rest_wreg == $past(live_wreg)
          && rest_bsr == $past(live_bsr))); // R2
      AST_CALL_SAVED_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(call_fast) && ret_exec && ret_is_fast && !vec_irq && !call_fast) |->
         (rest_status == $past(live_status) && rest_wreg == $past(live_wreg)
          && rest_bsr == $past(live_bsr))); // R3
   end else begin : g_lat1
      AST_PLAIN_RET_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         (ret_exec && !ret_is_fast) |=> !rest_load); // R5
      AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         (vec_irq || call_fast) |=> !rest_load); // R7
      AST_LOAD_AFTER_FAST_RET: assert property (@(posedge clk) disable iff (!rst_n)
         (ret_exec && ret_is_fast && !vec_irq && !call_fast) |=> rest_load); // R4
      AST_IRQ_SAVED_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(vec_irq) && ret_exec && ret_is_fast && !vec_irq && !call_fast) |=>
         (rest_status == $past(live_status, 2) && rest_wreg == $past(live_wreg, 2)
          && rest_bsr == $past(live_bsr, 2))); // R2
   end

endmodule

bind fast_ctx_shadow fcs_checker #(
   .STATUS_W    (STATUS_W),
   .WREG_W      (WREG_W),
   .BSR_W       (BSR_W),
   .RESTORE_LAT (RESTORE_LAT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .live_status (live_status),
   .live_wreg   (live_wreg),
   .live_bsr    (live_bsr),
   .vec_irq     (vec_irq),
   .call_fast   (call_fast),
   .ret_exec    (ret_exec),
   .ret_is_fast (ret_is_fast),
   .rest_load   (rest_load),
   .rest_status (rest_status),
   .rest_wreg   (rest_wreg),
   .rest_bsr    (rest_bsr)
);

// File: tb/fast_ctx_shadow_tb_top.sv
module fast_ctx_shadow_tb_top;

   localparam int SW = 5;
   localparam int WW = 8;
   localparam int BW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [SW-1:0] live_status = '0;
   logic [WW-1:0] live_wreg = '0;
   logic [BW-1:0] live_bsr = '0;
   logic          vec_irq = 1'b0, call_fast = 1'b0, ret_exec = 1'b0, ret_is_fast = 1'b0;

   logic          r0_load, r1_load;
   logic [SW-1:0] r0_st, r1_st;
   logic [WW-1:0] r0_wr, r1_wr;
   logic [BW-1:0] r0_bs, r1_bs;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // Behavioural model state.
   logic [SW-1:0] m_st = '0;
   logic [WW-1:0] m_wr = '0;
   logic [BW-1:0] m_bs = '0;
   logic          p_load = 1'b0;
   logic [SW-1:0] p_st = '0;
   logic [WW-1:0] p_wr = '0;
   logic [BW-1:0] p_bs = '0;

   always #4 clk = ~clk;   // 125 MHz

   fast_ctx_shadow #(.STATUS_W(SW), .WREG_W(WW), .BSR_W(BW), .RESTORE_LAT(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .live_status(live_status), .live_wreg(live_wreg),
      .live_bsr(live_bsr), .vec_irq(vec_irq), .call_fast(call_fast), .ret_exec(ret_exec),
      .ret_is_fast(ret_is_fast), .rest_load(r0_load), .rest_status(r0_st),
      .rest_wreg(r0_wr), .rest_bsr(r0_bs));

   fast_ctx_shadow #(.STATUS_W(SW), .WREG_W(WW), .BSR_W(BW), .RESTORE_LAT(1)) dut_lat1_i (
      .clk(clk), .rst_n(rst_n), .live_status(live_status), .live_wreg(live_wreg),
      .live_bsr(live_bsr), .vec_irq(vec_irq), .call_fast(call_fast), .ret_exec(ret_exec),
      .ret_is_fast(ret_is_fast), .rest_load(r1_load), .rest_status(r1_st),
      .rest_wreg(r1_wr), .rest_bsr(r1_bs));

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic cmp_both(input string tag, input logic e0_l, input int e0_s, input int e0_w,
                           input int e0_b, input logic e1_l, input int e1_s, input int e1_w,
                           input int e1_b);
      chk(tag, "lat0 load", int'(r0_load), int'(e0_l));
      chk(tag, "lat0 status", int'(r0_st), e0_s);
      chk(tag, "lat0 wreg", int'(r0_wr), e0_w);
      chk(tag, "lat0 bsr", int'(r0_bs), e0_b);
      chk(tag, "lat1 load", int'(r1_load), int'(e1_l));
      chk(tag, "lat1 status", int'(r1_st), e1_s);
      chk(tag, "lat1 wreg", int'(r1_wr), e1_w);
      chk(tag, "lat1 bsr", int'(r1_bs), e1_b);
   endtask

   // One clock of stimulus; compares both instances against the model before the edge.
   task automatic step(input logic irq, input logic call, input logic ret, input logic fast,
                       input int s, input int w, input int b, input string tag);
      logic          cap, fire;
      logic [SW-1:0] e_st;
      logic [WW-1:0] e_wr;
      logic [BW-1:0] e_bs;
      @(negedge clk);
      vec_irq = irq; call_fast = call; ret_exec = ret; ret_is_fast = fast;
      live_status = SW'(s); live_wreg = WW'(w); live_bsr = BW'(b);
      #3;
      cap  = irq | call;
      fire = ret & fast & ~cap;
      e_st = fire ? m_st : '0;
      e_wr = fire ? m_wr : '0;
      e_bs = fire ? m_bs : '0;
      cmp_both(tag, fire, int'(e_st), int'(e_wr), int'(e_bs),
               p_load, int'(p_st), int'(p_wr), int'(p_bs));
      p_load = fire; p_st = e_st; p_wr = e_wr; p_bs = e_bs;
      if (cap) begin
         m_st = SW'(s); m_wr = WW'(w); m_bs = BW'(b);
      end
   endtask

   initial begin : watchdog
      #(8 * 200000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      int seed;
      // R1: outputs quiet during reset
      repeat (3) @(negedge clk);
      ret_exec = 1'b1; ret_is_fast = 1'b0;
      #3;
      cmp_both("R1", 1'b0, 0, 0, 0, 1'b0, 0, 0, 0);
      ret_exec = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      step(0, 0, 1, 1, 31, 255, 255, "R1");         // first fast return gives zeros
      step(0, 0, 0, 0, 3, 4, 5, "R9");
      step(1, 0, 0, 0, 21, 8'hA5, 8'h3C, "R2");      // interrupt capture
      step(0, 0, 0, 0, 1, 2, 3, "R5");               // live changes only
      step(0, 0, 1, 1, 0, 0, 0, "R4");               // restore A
      step(0, 0, 1, 0, 9, 9, 9, "R5");               // plain return
      step(0, 0, 1, 1, 0, 0, 0, "R8");               // restore A again
      step(0, 1, 0, 0, 7, 8'h11, 8'hE0, "R3");       // fast call capture
      step(0, 0, 1, 1, 0, 0, 0, "R3");
      step(1, 0, 0, 0, 4, 8'h40, 8'h01, "R6");       // low-priority capture
      step(1, 0, 0, 0, 12, 8'hC3, 8'h0F, "R6");      // nested capture overwrites
      step(0, 0, 1, 1, 0, 0, 0, "R6");
      step(1, 0, 1, 1, 30, 8'h77, 8'h88, "R7");      // capture and fast return together
      step(0, 1, 1, 1, 17, 8'h5A, 8'h99, "R7");
      step(0, 0, 1, 1, 0, 0, 0, "R7");
      step(1, 1, 0, 0, 19, 8'hFE, 8'h02, "R3");      // both capture strobes
      step(0, 0, 0, 1, 6, 6, 6, "R5");               // fast flag without a return
      step(0, 0, 1, 1, 0, 0, 0, "R3");
      step(0, 0, 0, 0, 0, 0, 0, "R9");

      seed = 32'h1F2E3D4C;
      for (int i = 0; i < 400; i++) begin
         seed = seed * 1103515245 + 12345;
         step(seed[20] & seed[21], seed[22] & seed[23] & seed[24], seed[25], seed[26] | seed[27],
              seed[4:0], seed[12:5], seed[19:12], "R4");
      end
      step(0, 0, 0, 0, 0, 0, 0, "R9");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule